// File: doc/BRIEF.md
# Registered Barrel Shifter with Carry and Extend Flags

This block shifts a 32-bit operand left logically, right logically or right arithmetically by an amount supplied from a register. It returns the shifted word together with a carry bit and an extend bit that follow the condition-code rules of a classic two-flag processor. The shift amount is reduced to its low six bits, so every amount from 0 to 63 has a defined outcome. Amounts of 32 and above are not folded back into the 0..31 range. They produce the specific results and carry values listed below.

A shift of zero does not invent a carry: the caller supplies the carry flag currently held by the processor, and that bit is returned unchanged. The arithmetic runs in one combinational pass through a logarithmic shift network. The result and flags are then captured in an output register whenever the operation-valid input is high. Rotates and the negative/zero flags are computed elsewhere.

The operation code is two bits wide: 00 shifts left logically, 01 shifts right logically, 10 shifts right arithmetically, and 11 passes the operand through.

Top module: `shift_flag_unit`

## Requirements
- R1: While reset is asserted and after it is released, before any operation is accepted, out_valid, out_result, out_carry and out_extend are all 0.
- R2: Only the low 6 bits of in_count set the shift amount. The upper bits of in_count have no effect, so a count of 0x41 acts as a shift of 1.
- R3: With a masked amount of 0 and any shift code, out_result equals in_value and out_carry equals in_carry_prev.
- R4: For code 00 (left) with amount n in 1..31, out_result is in_value shifted left by n with zeros entering, and out_carry is input bit 32-n.
- R5: For code 00 with amount exactly 32, out_result is 0 and out_carry is input bit 0.
- R6: For code 01 (logical right) with amount n in 1..31, out_result is in_value shifted right by n with zeros entering, and out_carry is input bit n-1.
- R7: For code 01 with amount exactly 32, out_result is 0 and out_carry is input bit 31.
- R8: For code 00 or 01 with amount 33..63, out_result is 0 and out_carry is 0.
- R9: For code 10 (arithmetic right) with amount n in 1..31, out_result is in_value shifted right by n with copies of bit 31 entering, and out_carry is input bit n-1.
- R10: For code 10 with amount 32..63, every bit of out_result equals input bit 31, and out_carry equals input bit 31.
- R11: For code 11, out_result equals in_value and out_carry equals in_carry_prev, whatever the amount.
- R12: out_extend equals out_carry after every accepted operation and after reset.
- R13: The outputs reflect an operation one clock edge after it is presented with in_valid high. While in_valid is low, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture the operation at this edge |
| in_value | input | 32 | Operand to shift |
| in_count | input | 8 | Shift amount from a register; only the low 6 bits are used |
| in_op | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 pass |
| in_carry_prev | input | 1 | Current carry flag of the processor |
| out_valid | output | 1 | High after an operation has been captured |
| out_result | output | 32 | Registered shifted word |
| out_carry | output | 1 | Registered carry-out |
| out_extend | output | 1 | Registered extend flag, same as carry-out |

## Verification
A zero-amount operation and the landing of the previous operation's carry can occur in the same cycle. This happens when the carry the shifter has just produced is fed straight back as in_carry_prev for a zero-amount shift on the next edge. The bench runs two back-to-back valid cycles. The first cycle leaves carry 1, or in a second pass carry 0. On the following negative edge, the bench copies out_carry into in_carry_prev for a zero-amount shift. The retained carry must equal the value produced one cycle earlier, and the operand must pass through untouched.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SHF_LSL  = 2'b00,
    SHF_LSR  = 2'b01,
    SHF_ASR  = 2'b10,
    SHF_PASS = 2'b11
  } shf_op_e;

  typedef enum logic [1:0] {
    AMT_ZERO  = 2'b00,
    AMT_SMALL = 2'b01,
    AMT_EXACT = 2'b10,
    AMT_WIDE  = 2'b11
  } amt_class_e;
endpackage

// File: rtl/shf_count_class.sv
module shf_count_class #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  localparam int LOG_W  = $clog2(DATA_W),
  localparam int MASK_W = LOG_W + 1
) (
  input  logic [CNT_W-1:0]  count_raw,
  output logic [MASK_W-1:0] count_masked,
  output logic [LOG_W-1:0]  amt,
  output shf_pkg::amt_class_e amt_class
);
  import shf_pkg::*;

  localparam logic [MASK_W-1:0] WIDTH_CNT = MASK_W'(DATA_W);

  always_comb begin
    count_masked = count_raw[MASK_W-1:0];
    amt          = count_masked[LOG_W-1:0];
    if (count_masked == '0)
      amt_class = AMT_ZERO;
    else if (count_masked < WIDTH_CNT)
      amt_class = AMT_SMALL;
    else if (count_masked == WIDTH_CNT)
      amt_class = AMT_EXACT;
    else
      amt_class = AMT_WIDE;
  end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
  parameter int DATA_W = 32,
  localparam int LOG_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [LOG_W-1:0]  amt,
  input  logic              fill,
  input  logic              to_left,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] rin;
  logic [DATA_W-1:0] rout;
  logic [DATA_W-1:0] stg [0:LOG_W];

  // Left shifts reuse the right-shift network on a bit-reversed word.
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign rin[i]  = to_left ? din[DATA_W-1-i] : din[i];
    assign dout[i] = to_left ? rout[DATA_W-1-i] : rout[i];
  end

  assign stg[0] = rin;

  for (genvar k = 0; k < LOG_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stg[k+1] = amt[k] ? {{SH{fill}}, stg[k][DATA_W-1:SH]} : stg[k];
  end

  assign rout = stg[LOG_W];
endmodule

// File: rtl/shf_out_reg.sv
module shf_out_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] d_result,
  input  logic              d_carry,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_result,
  output logic              q_carry,
  output logic              q_extend
);
  logic              nxt_valid;
  logic [DATA_W-1:0] nxt_result;
  logic              nxt_carry;
  logic              nxt_extend;

  always_comb begin
    nxt_valid  = q_valid;
    nxt_result = q_result;
    nxt_carry  = q_carry;
    nxt_extend = q_extend;
    if (en) begin
      nxt_valid  = 1'b1;
      nxt_result = d_result;
      nxt_carry  = d_carry;
      nxt_extend = d_carry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_result <= '0;
      q_carry  <= 1'b0;
      q_extend <= 1'b0;
    end else begin
      q_valid  <= nxt_valid;
      q_result <= nxt_result;
      q_carry  <= nxt_carry;
      q_extend <= nxt_extend;
    end
  end

  AST_EXTEND_FOLLOWS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    q_extend == q_carry); // R12
endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  localparam int LOG_W  = $clog2(DATA_W),
  localparam int MASK_W = LOG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_value,
  input  logic [CNT_W-1:0]  in_count,
  input  logic [1:0]        in_op,
  input  logic              in_carry_prev,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_carry,
  output logic              out_extend
);
  import shf_pkg::*;

  logic [MASK_W-1:0]  cnt_m;
  logic [LOG_W-1:0]   amt;
  amt_class_e         amt_cls;
  shf_op_e            op;
  logic               sign;
  logic               is_left;
  logic               is_arith;
  logic [DATA_W-1:0]  shifted;
  logic [LOG_W-1:0]   idx_left;
  logic [LOG_W-1:0]   idx_right;
  logic [DATA_W-1:0]  res_c;
  logic               carry_c;

  assign op       = shf_op_e'(in_op);
  assign sign     = in_value[DATA_W-1];
  assign is_left  = (op == SHF_LSL);
  assign is_arith = (op == SHF_ASR);

  shf_count_class #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cls (
    .count_raw    (in_count),
    .count_masked (cnt_m),
    .amt          (amt),
    .amt_class    (amt_cls)
  );

  shf_barrel #(.DATA_W(DATA_W)) u_bar (
    .din     (in_value),
    .amt     (amt),
    .fill    (is_arith & sign),
    .to_left (is_left),
    .dout    (shifted)
  );

  // Last bit out: width minus amount for left, amount minus one for right.
  assign idx_left  = {LOG_W{1'b0}} - amt;
  assign idx_right = amt - {{(LOG_W-1){1'b0}}, 1'b1};

  always_comb begin
    res_c   = in_value;
    carry_c = in_carry_prev;
    if (op != SHF_PASS) begin
      unique case (amt_cls)
        AMT_ZERO: begin
          res_c   = in_value;
          carry_c = in_carry_prev;
        end
        AMT_SMALL: begin
          res_c   = shifted;
          carry_c = is_left ? in_value[idx_left] : in_value[idx_right];
        end
        AMT_EXACT: begin
          res_c   = is_arith ? {DATA_W{sign}} : '0;
          carry_c = is_left ? in_value[0] : sign;
        end
        AMT_WIDE: begin
          res_c   = is_arith ? {DATA_W{sign}} : '0;
          carry_c = is_arith & sign;
        end
        default: begin
          res_c   = in_value;
          carry_c = in_carry_prev;
        end
      endcase
    end
  end

  shf_out_reg #(.DATA_W(DATA_W)) u_oreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (in_valid),
    .d_result (res_c),
    .d_carry  (carry_c),
    .q_valid  (out_valid),
    .q_result (out_result),
    .q_carry  (out_carry),
    .q_extend (out_extend)
  );

  AST_ZERO_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_count[MASK_W-1:0] == '0) |=>
      (out_carry == $past(in_carry_prev) && out_result == $past(in_value))); // R3
  AST_LOGIC_WIDE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_op[1] && in_count[MASK_W-1:0] > MASK_W'(DATA_W)) |=>
      (out_result == '0 && !out_carry)); // R8
  AST_ARITH_WIDE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b10 && in_count[MASK_W-1:0] >= MASK_W'(DATA_W)) |=>
      (out_result == {DATA_W{$past(in_value[DATA_W-1])}} &&
       out_carry == $past(in_value[DATA_W-1]))); // R10
  AST_PASS_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b11) |=>
      (out_result == $past(in_value) && out_carry == $past(in_carry_prev))); // R11
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_carry) && $stable(out_valid))); // R13
endmodule

// File: tb/shift_flag_unit_test.sv
module shift_flag_unit_test;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_value;
  logic [7:0]  in_count;
  logic [1:0]  in_op;
  logic        in_carry_prev;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_carry;
  logic        out_extend;

  int total = 0;
  int bad   = 0;

  shift_flag_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
    .in_count(in_count), .in_op(in_op), .in_carry_prev(in_carry_prev),
    .out_valid(out_valid), .out_result(out_result), .out_carry(out_carry),
    .out_extend(out_extend)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // Expected outcome, written from the requirement list.
  function automatic logic [32:0] model(input logic [31:0] v, input logic [7:0] c,
                                        input logic [1:0] op, input logic prev);
    int n;
    logic [31:0] r;
    logic        cy;
    n = int'(c) % 64;
    r = v; cy = prev;
    if (op != 2'b11 && n != 0) begin
      case (op)
        2'b00: begin
          if (n < 32) begin r = v << n; cy = v[32-n]; end
          else if (n == 32) begin r = 0; cy = v[0]; end
          else begin r = 0; cy = 0; end
        end
        2'b01: begin
          if (n < 32) begin r = v >> n; cy = v[n-1]; end
          else if (n == 32) begin r = 0; cy = v[31]; end
          else begin r = 0; cy = 0; end
        end
        default: begin
          if (n < 32) begin r = 32'($signed(v) >>> n); cy = v[n-1]; end
          else begin r = {32{v[31]}}; cy = v[31]; end
        end
      endcase
    end
    return {cy, r};
  endfunction

  task automatic check(input string req, input logic [31:0] er, input logic ec);
    total++;
    if (out_result !== er || out_carry !== ec || out_extend !== ec || out_valid !== 1'b1) begin
      bad++;
      $display("FAIL %s: result=%h carry=%b ext=%b valid=%b expected result=%h carry=%b ext=%b",
               req, out_result, out_carry, out_extend, out_valid, er, ec, ec);
    end
  endtask

  task automatic run_op(input string req, input logic [31:0] v, input logic [7:0] c,
                        input logic [1:0] op, input logic prev);
    logic [32:0] e;
    e = model(v, c, op, prev);
    @(negedge clk);
    in_valid = 1'b1; in_value = v; in_count = c; in_op = op; in_carry_prev = prev;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, e[31:0], e[32]);
  endtask

  task automatic t_reset();
    total++;
    if (out_valid !== 0 || out_result !== 0 || out_carry !== 0 || out_extend !== 0) begin
      bad++;
      $display("FAIL R1: valid=%b result=%h carry=%b ext=%b expected all zero",
               out_valid, out_result, out_carry, out_extend);
    end
  endtask

  task automatic t_left();
    run_op("R4", 32'h8000_0001, 8'd1, 2'b00, 1'b0);
    run_op("R4", 32'h1234_5678, 8'd4, 2'b00, 1'b0);
    run_op("R4", 32'h0000_0003, 8'd31, 2'b00, 1'b1);
    run_op("R4", 32'h4000_0000, 8'd31, 2'b00, 1'b0);
    run_op("R5", 32'h0000_0001, 8'd32, 2'b00, 1'b0);
    run_op("R5", 32'hFFFF_FFFE, 8'd32, 2'b00, 1'b1);
  endtask

  task automatic t_right();
    run_op("R6", 32'h0000_0001, 8'd1, 2'b01, 1'b0);
    run_op("R6", 32'hF000_00F0, 8'd5, 2'b01, 1'b1);
    run_op("R6", 32'h8000_0000, 8'd31, 2'b01, 1'b0);
    run_op("R7", 32'h8000_0000, 8'd32, 2'b01, 1'b0);
    run_op("R7", 32'h7FFF_FFFF, 8'd32, 2'b01, 1'b1);
  endtask

  task automatic t_wide_logic();
    run_op("R8", 32'hFFFF_FFFF, 8'd33, 2'b00, 1'b1);
    run_op("R8", 32'hFFFF_FFFF, 8'd63, 2'b01, 1'b1);
  endtask

  task automatic t_arith();
    run_op("R9", 32'h8000_0010, 8'd4, 2'b10, 1'b0);
    run_op("R9", 32'h8000_0008, 8'd4, 2'b10, 1'b0);
    run_op("R9", 32'h7000_0000, 8'd31, 2'b10, 1'b1);
    run_op("R10", 32'h8000_0000, 8'd32, 2'b10, 1'b0);
    run_op("R10", 32'h8000_0000, 8'd63, 2'b10, 1'b0);
    run_op("R10", 32'h7FFF_FFFF, 8'd40, 2'b10, 1'b1);
  endtask

  task automatic t_zero();
    run_op("R3", 32'hDEAD_BEEF, 8'd0, 2'b00, 1'b1);
    run_op("R3", 32'hDEAD_BEEF, 8'd0, 2'b10, 1'b0);
    run_op("R3", 32'h0000_0001, 8'd64, 2'b01, 1'b1);
  endtask

  task automatic t_pass();
    run_op("R11", 32'hCAFE_0001, 8'd5, 2'b11, 1'b1);
    run_op("R11", 32'hCAFE_0002, 8'd40, 2'b11, 1'b0);
  endtask

  task automatic t_mask();
    run_op("R2", 32'h8000_0001, 8'h41, 2'b01, 1'b0);
    run_op("R2", 32'h0000_0001, 8'hE0, 2'b00, 1'b0);
  endtask

  task automatic t_hold();
    logic [31:0] r0;
    logic        c0;
    run_op("R13", 32'h0000_00FF, 8'd1, 2'b01, 1'b0);
    r0 = out_result; c0 = out_carry;
    @(negedge clk);
    in_valid = 1'b0; in_value = 32'h1111_1111; in_count = 8'd3; in_op = 2'b00;
    in_carry_prev = 1'b0;
    @(negedge clk);
    @(negedge clk);
    total++;
    if (out_result !== r0 || out_carry !== c0 || out_extend !== c0) begin
      bad++;
      $display("FAIL R13: result=%h carry=%b expected held result=%h carry=%b",
               out_result, out_carry, r0, c0);
    end
  endtask

  // Carry from one operation feeds a zero-amount shift on the next edge (R3, R13).
  task automatic t_chain(input logic [31:0] v, input logic [7:0] c);
    logic [32:0] e1;
    e1 = model(v, c, 2'b01, 1'b0);
    @(negedge clk);
    in_valid = 1'b1; in_value = v; in_count = c; in_op = 2'b01; in_carry_prev = 1'b0;
    @(negedge clk);
    check("R13", e1[31:0], e1[32]);
    in_valid = 1'b1; in_value = 32'hA5A5_5A5A; in_count = 8'd0; in_op = 2'b01;
    in_carry_prev = out_carry;
    @(negedge clk);
    in_valid = 1'b0;
    check("R3", 32'hA5A5_5A5A, e1[32]);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_value = '0; in_count = '0; in_op = '0;
    in_carry_prev = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_left();
    t_right();
    t_wide_logic();
    t_arith();
    t_zero();
    t_pass();
    t_mask();
    t_hold();
    t_chain(32'h0000_0002, 8'd2);
    t_chain(32'h0000_0002, 8'd1);
    finish_run();
  end
endmodule